// File: doc/BRIEF.md
# Clocked Serial Byte Shifter

This block moves one byte at a time over a three-wire synchronous serial link. A parallel write puts a byte into an 8-bit shift register and starts a transfer. The register then shifts out on the data-out line while it takes in the data-in line, one bit per serial clock period. The byte received from the far end ends up in the same register, where a parallel read returns it. A completion flag goes high once all eight bit times have passed.

The serial clock can come from either of two sources, chosen by a mode input at run time. In internal mode the block acts as master: it makes the clock from the system clock with a programmable divider. In external mode it follows a clock pin driven by another device, which it samples through a two-flop synchronizer. Typical use is to write the divider once, write a byte, wait for the flag, and read the answer.

Top module: `ser_shift_port`

## Requirements
- R1: After reset, `done`, `busy`, `sdo`, `sck_out` and `rd_data` are all 0, and the divider holds `DIV_RST`.
- R2: A cycle with `wr_en` high loads `wr_data` at that clock edge, so the next cycle shows `busy`=1, `done`=0 and `sdo`=`wr_data[7]`.
- R3: In internal mode (`ext_sel`=0), the half period of `sck_out` is value+1 system clocks, where value is the last number written through `div_wr`/`div_data`. `sck_out` idles low and gives exactly eight high pulses per transfer.
- R4: Data leaves most significant bit first. In internal mode `sdo` changes only on the clock edge where `sck_out` falls, or on a load.
- R5: `sdi` is captured at the rising serial clock. After eight bits, `rd_data` holds the captured bits, with the first bit captured in bit 7.
- R6: `done` rises on the edge of the eighth falling serial clock, 16×(value+1) system clocks after the load in internal mode. `busy` clears on the same edge. `done` then stays high until the next load.
- R7: A load while `busy` is high restarts the transfer: `done` stays 0, the bit count returns to zero and the full 16×(value+1) cycles are needed again.
- R8: In external mode (`ext_sel`=1), `sck_in` passes through a two-flop synchronizer. A synchronized rising edge samples `sdi` and a synchronized falling edge shifts. `sck_out` stays low.
- R9: If a load lands on the same edge as the eighth falling serial clock, the load wins: `done` stays 0 and a new transfer of the new byte begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Parallel load strobe, starts a transfer |
| wr_data | input | 8 | Byte to send |
| div_wr | input | 1 | Divider write strobe |
| div_data | input | DIV_W | Divider value; half period is value+1 clocks |
| ext_sel | input | 1 | 1 = follow `sck_in`, 0 = generate clock internally |
| sck_in | input | 1 | External serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (MSB of the shift register) |
| sck_out | output | 1 | Internally generated serial clock |
| rd_data | output | 8 | Shift register contents / received byte |
| done | output | 1 | Transfer complete flag |
| busy | output | 1 | Transfer in progress |

## Verification
A new load and the completion of the eighth bit can fall on the same clock edge. The bench provokes this by counting exactly 16×(value+1)−1 cycles after a load and raising `wr_en` for the next edge. That is the edge on which `done` would otherwise set. The result is judged at the ports: `done` must stay 0 and `busy` must stay 1. The restarted transfer must then finish with the second byte's bit count and return the expected received byte.

// File: rtl/ser_shift_port.sv
module ser_shift_port #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 3,
  parameter int NBITS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NBITS-1:0] wr_data,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  input  logic             ext_sel,
  input  logic             sck_in,
  input  logic             sdi,
  output logic             sdo,
  output logic             sck_out,
  output logic [NBITS-1:0] rd_data,
  output logic             done,
  output logic             busy
);
  localparam int BC_W = $clog2(NBITS);
  localparam logic [BC_W-1:0] LAST = BC_W'(NBITS - 1);

  logic [NBITS-1:0] sh_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [BC_W-1:0]  bits_q;
  logic             sck_q, samp_q, busy_q, done_q;
  logic [2:0]       sync_q;

  logic tick, ext_rise, ext_fall, rise_ev, fall_ev;

  assign tick     = (cnt_q == div_q);
  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign ext_fall = ~sync_q[1] & sync_q[2];
  assign rise_ev  = ext_sel ? ext_rise : (tick & ~sck_q);
  assign fall_ev  = ext_sel ? ext_fall : (tick & sck_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      div_q  <= DIV_W'(DIV_RST);
      cnt_q  <= '0;
      bits_q <= '0;
      sck_q  <= 1'b0;
      samp_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sck_in};
      if (div_wr) div_q <= div_data;
      if (wr_en) begin
        sh_q   <= wr_data;
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt_q  <= '0;
        bits_q <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= (ext_sel || tick) ? '0 : cnt_q + 1'b1;
        if (ext_sel) sck_q <= 1'b0;
        else if (tick) sck_q <= ~sck_q;
        if (rise_ev) samp_q <= sdi;
        if (fall_ev) begin
          sh_q   <= {sh_q[NBITS-2:0], samp_q};
          bits_q <= bits_q + 1'b1;
          if (bits_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sdo     = sh_q[NBITS-1];
  assign sck_out = sck_q;
  assign rd_data = sh_q;
  assign done    = done_q;
  assign busy    = busy_q;
endmodule

// File: rtl/ser_shift_port_chk.sv
module ser_shift_port_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic ext_sel,
  input logic sck_out,
  input logic sdo,
  input logic done,
  input logic busy
);
  // R2
  load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (busy && !done));

  // R3
  sck_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_out |-> busy);

  // R4
  sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ext_sel) && !$past(wr_en) && !$fell(sck_out)) |-> $stable(sdo));

  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));

  // R6
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en) |=> done);

  // R8
  ext_no_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_sel) && ext_sel) |-> !sck_out);
endmodule

bind ser_shift_port ser_shift_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ext_sel(ext_sel),
  .sck_out(sck_out), .sdo(sdo), .done(done), .busy(busy)
);

// File: tb/tb_ser_shift_port.sv
module tb_ser_shift_port;
  logic clk = 0, rst_n = 0, wr_en = 0, div_wr = 0, ext_sel = 0, sck_in = 0, sdi = 0;
  logic [7:0] wr_data = 0, div_data = 0;
  logic sdo, sck_out, done, busy;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ser_shift_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div_wr(div_wr), .div_data(div_data), .ext_sel(ext_sel), .sck_in(sck_in),
    .sdi(sdi), .sdo(sdo), .sck_out(sck_out), .rd_data(rd_data),
    .done(done), .busy(busy)
  );

  // {div, tx byte, rx byte}
  localparam logic [23:0] VEC [4] = '{
    {8'd0, 8'hA5, 8'h3C},
    {8'd1, 8'h81, 8'hFE},
    {8'd3, 8'h00, 8'h96},
    {8'd5, 8'h7E, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_div(input logic [7:0] d);
    div_data = d; div_wr = 1; @(negedge clk); div_wr = 0;
  endtask

  task automatic load(input logic [7:0] b);
    wr_data = b; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  task automatic run_int(input logic [7:0] d, input logic [7:0] tx, input logic [7:0] rx);
    int hi, pulses;
    set_div(d);
    sdi = rx[7];
    load(tx);
    chk(busy && !done && sdo == tx[7], "R2 load", {busy, done, sdo}, {2'b10, tx[7]});
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      while (!sck_out) @(negedge clk);
      pulses++;
      chk(sdo == tx[7-i], "R4 msb-first out", sdo, tx[7-i]);
      hi = 0;
      while (sck_out) begin @(negedge clk); hi++; end
      chk(hi == d + 1, "R3 half period", hi, d + 1);
      if (i < 7) sdi = rx[6-i];
    end
    chk(done && !busy, "R6 done after 8 bits", {done, busy}, 2'b10);
    chk(rd_data == rx, "R5 received byte", rd_data, rx);
    repeat (2 * (d + 1) + 2) begin
      @(negedge clk);
      if (sck_out) pulses++;
    end
    chk(pulses == 8 && !sck_out, "R3 eight pulses idle low", pulses, 8);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !sdo && !sck_out && rd_data == 0, "R1 reset outputs",
        {done, busy, sdo, sck_out, rd_data}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 default divider: half period DIV_RST+1 = 4
    load(8'h40);
    n = 0;
    while (!done) begin @(negedge clk); n++; if (n > 500) break; end
    chk(n == 64, "R1 default divider", n, 64);

    for (int v = 0; v < 4; v++)
      run_int(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);

    // R7 reload mid-transfer
    set_div(8'd1);
    sdi = 1;
    load(8'h11);
    repeat (13) @(negedge clk);
    load(8'hC3);
    chk(busy && !done && sdo == 1'b1, "R7 restart state", {busy, done, sdo}, 3'b101);
    n = 0;
    while (!done) begin @(negedge clk); n++; if (n > 500) break; end
    chk(n == 32, "R7 full length after restart", n, 32);
    chk(rd_data == 8'hFF, "R7 received byte", rd_data, 8'hFF);

    // R9 load collides with final falling edge
    sdi = 0;
    load(8'h5A);
    repeat (31) @(negedge clk);
    sdi = 1;
    load(8'hF0);
    chk(!done && busy, "R9 load wins over completion", {done, busy}, 2'b01);
    chk(sdo == 1'b1, "R9 new byte msb", sdo, 1);
    n = 0;
    while (!done) begin @(negedge clk); n++; if (n > 500) break; end
    chk(n == 32 && rd_data == 8'hFF, "R9 restarted transfer", rd_data, 8'hFF);

    // R8 external clock
    ext_sel = 1;
    begin
      logic [7:0] tx, rx;
      bit sck_seen;
      tx = 8'hB4; rx = 8'h6D;
      sck_seen = 0;
      load(tx);
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        chk(sdo == tx[7-i], "R8 ext sdo bit", sdo, tx[7-i]);
        sdi = rx[7-i];
        sck_in = 1;
        repeat (4) begin @(negedge clk); if (sck_out) sck_seen = 1; end
        sck_in = 0;
        repeat (4) begin @(negedge clk); if (sck_out) sck_seen = 1; end
      end
      chk(done && !busy, "R8 ext done", {done, busy}, 2'b10);
      chk(rd_data == rx, "R8 ext received byte", rd_data, rx);
      chk(!sck_seen, "R8 sck_out quiet", sck_seen, 0);
    end
    ext_sel = 0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule